// File: doc/BRIEF.md
# DMA Loop Iteration and Channel Link Controller

This block is the per-channel loop-control unit of a multi-channel DMA engine. For every channel it keeps a destination address, a signed destination step, a running iteration word and a reload iteration word. It also keeps a separate link setting that is used when the whole transfer finishes, plus a start flag and a done flag. The data mover reports each finished inner (minor) loop with a one-cycle pulse and a channel number. The block then moves that channel's destination address forward by the step and counts the iteration down. Depending on the state of the channel, it arms the start flag of a linked channel.

The running iteration word is read in one of two ways, chosen at run time by its top bit. With the bit clear, the word holds a 15-bit counter. With the bit set, the word holds a 6-bit link-target channel and a 9-bit counter. On the last iteration the minor-loop link is not issued. The counter is reloaded, the done flag is raised, and the separate completion link decides which channel, if any, is started next. Channels whose settings contradict each other are flagged and do not advance.

Software sees each channel as a 32-byte descriptor slot. Four 32-bit words of that slot are mapped, and the other four read as zero.

Top module: `dma_iter_link`

## Requirements
- R1: After reset, every stored field is zero and `start_o`, `done_o` and `cfg_err_o` are all low.
- R2: Channel n occupies byte offsets 32·n to 32·n+31 of `reg_addr`, and `reg_rdata` shows the addressed word in the same cycle. The mapped words are:
  - 0x10: destination address.
  - 0x14: iteration word in bits 31:16 and destination step in bits 15:0.
  - 0x18: start flag in bit 0 and done flag in bit 1.
  - 0x1C: reload iteration word in bits 31:16, completion-link enable in bit 7 and completion-link channel in bits 5:0.
  
  Words 0x00 to 0x0C read zero and writes to them change nothing.
- R3: On an accepted minor-loop pulse, the channel's destination address becomes the address plus the step, sign-extended from 16 bits. The sum wraps modulo 2^32.
- R4: In an iteration word, bit 15 is the link enable. When it is set, bits 14:9 are the link channel and bits 8:0 are the count. When it is clear, bits 14:0 are the count. A non-final minor loop decrements only the count and keeps the upper fields.
- R5: On an accepted minor loop that is not final, if bit 15 of the iteration word is set, `link_fire` pulses in that cycle with `link_tgt` equal to bits 14:9. The target's start flag is high on the next cycle.
- R6: A minor loop is final when its count is 0 or 1. On a final minor loop, `major_fire` pulses, the iteration word is reloaded from the reload word, the done flag is set, and no minor-loop link is issued.
- R7: On a final minor loop, if the completion-link enable is set, `link_fire` pulses with `link_tgt` equal to the completion-link channel, and that channel's start flag is set on the next cycle.
- R8: An accepted minor loop clears the serviced channel's start flag, unless the same event links to that channel. In that case the flag stays set.
- R9: `cfg_err_o[n]` is high in any of these cases:
  - Bit 15 of the iteration word differs from bit 15 of the reload word.
  - Linking is enabled in the iteration word and its link channel is at least NUM_CH.
  - The completion link is enabled and its channel is at least NUM_CH.
  
  A minor-loop pulse on a flagged channel changes nothing and fires nothing.
- R10: A register write in the same cycle as a minor-loop update takes effect on the written word and overrides that word's hardware update. Other words still take the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CH_W+5 | Byte offset into the descriptor region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ml_done | input | 1 | Minor-loop completion pulse |
| ml_ch | input | CH_W | Channel that completed its minor loop |
| start_o | output | NUM_CH | Per-channel start flags |
| done_o | output | NUM_CH | Per-channel major-loop done flags |
| cfg_err_o | output | NUM_CH | Per-channel configuration error |
| link_fire | output | 1 | A link start request is issued this cycle |
| link_tgt | output | 6 | Channel targeted by `link_fire` |
| major_fire | output | 1 | The accepted minor loop ended the major loop |

## Verification
The bench targets the following corner cases:
- **Last iteration of a linked channel.** A design that does not suppress the minor-loop link there fires the wrong target, or fires two requests.
- **Self-link.** A design that lets the service clear win over the link set drops the re-armed start flag.
- **Negative steps that wrap the address.** A design that zero-extends the step moves the address the wrong way.
- **Channels whose link-enable bits disagree or whose targets are out of range.** A design that lets these advance corrupts the address and counter.
- **A register write racing a minor-loop update.** A design that gives priority to the wrong side loses the software value.

// File: rtl/dma_iter_link_pkg.sv
package dma_iter_link_pkg;

  typedef struct packed {
    logic [31:0] daddr;
    logic [15:0] citer;
    logic [15:0] doff;
    logic [15:0] biter;
    logic        mlen;
    logic [5:0]  mlch;
  } desc_t;

  localparam logic [2:0] W_DADDR = 3'd4;
  localparam logic [2:0] W_ITER  = 3'd5;
  localparam logic [2:0] W_FLAGS = 3'd6;
  localparam logic [2:0] W_RELD  = 3'd7;

  function automatic logic [31:0] dest_advance(input logic [31:0] a, input logic [15:0] off);
    return a + {{16{off[15]}}, off};
  endfunction

  function automatic logic [14:0] iter_count(input logic [15:0] w);
    return w[15] ? {6'd0, w[8:0]} : w[14:0];
  endfunction

  function automatic logic [15:0] iter_decrement(input logic [15:0] w);
    logic [15:0] r;
    r = w;
    if (w[15]) r[8:0]  = w[8:0] - 9'd1;
    else       r[14:0] = w[14:0] - 15'd1;
    return r;
  endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check #(
  parameter int NUM_CH = 8
) (
  input  logic [15:0] citer,
  input  logic [15:0] biter,
  input  logic        maj_en,
  input  logic [5:0]  maj_ch,
  output logic        err
);
  logic flag_mismatch, minor_range, major_range;

  assign flag_mismatch = citer[15] != biter[15];
  assign minor_range   = citer[15] && ({26'd0, citer[14:9]} >= 32'(NUM_CH));
  assign major_range   = maj_en && ({26'd0, maj_ch} >= 32'(NUM_CH));
  assign err           = flag_mismatch | minor_range | major_range;
endmodule

// File: rtl/dma_loop_step.sv
module dma_loop_step
  import dma_iter_link_pkg::*;
(
  input  desc_t      cur,
  output desc_t      nxt,
  output logic       last,
  output logic [5:0] minor_tgt
);
  always_comb begin
    nxt       = cur;
    nxt.daddr = dest_advance(cur.daddr, cur.doff);
    last      = iter_count(cur.citer) <= 15'd1;
    nxt.citer = last ? cur.biter : iter_decrement(cur.citer);
    minor_tgt = cur.citer[14:9];
  end
endmodule

// File: rtl/dma_iter_link.sv
module dma_iter_link
  import dma_iter_link_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ml_done,
  input  logic [CH_W-1:0]   ml_ch,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] cfg_err_o,
  output logic              link_fire,
  output logic [5:0]        link_tgt,
  output logic              major_fire
);
  localparam bit FULL_MAP = (NUM_CH == (1 << CH_W));

  desc_t             desc_q [NUM_CH];
  logic [NUM_CH-1:0] start_q, done_q;

  // register port decode
  logic [CH_W-1:0] acc_ch;
  logic [2:0]      acc_word;
  logic            acc_hit, ml_ok;

  assign acc_ch   = reg_addr[ADDR_W-1:5];
  assign acc_word = reg_addr[4:2];

  generate
    if (FULL_MAP) begin : g_full
      assign acc_hit = 1'b1;
      assign ml_ok   = 1'b1;
    end else begin : g_part
      assign acc_hit = {{(32-CH_W){1'b0}}, acc_ch} < 32'(NUM_CH);
      assign ml_ok   = {{(32-CH_W){1'b0}}, ml_ch} < 32'(NUM_CH);
    end
  endgenerate

  // configuration checks, one per channel
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      dma_cfg_check #(.NUM_CH(NUM_CH)) u_chk (
        .citer (desc_q[c].citer),
        .biter (desc_q[c].biter),
        .maj_en(desc_q[c].mlen),
        .maj_ch(desc_q[c].mlch),
        .err   (cfg_err_o[c])
      );
    end
  endgenerate

  // selected channel and its loop step
  desc_t      sel_d, step_d;
  logic       step_last;
  logic [5:0] step_tgt;
  logic       sel_err;

  always_comb begin
    sel_d   = '0;
    sel_err = 1'b0;
    if (ml_ok) begin
      sel_d   = desc_q[ml_ch];
      sel_err = cfg_err_o[ml_ch];
    end
  end

  dma_loop_step u_step (
    .cur      (sel_d),
    .nxt      (step_d),
    .last     (step_last),
    .minor_tgt(step_tgt)
  );

  // named events
  logic ev_accept, minor_link, major_link;

  assign ev_accept  = ml_done && ml_ok && !sel_err;
  assign major_fire = ev_accept && step_last;
  assign minor_link = ev_accept && !step_last && sel_d.citer[15];
  assign major_link = major_fire && sel_d.mlen;
  assign link_fire  = minor_link | major_link;
  assign link_tgt   = major_link ? sel_d.mlch : step_tgt;

  logic [CH_W-1:0] link_idx;
  assign link_idx = link_tgt[CH_W-1:0];

  // state update: hardware first, register write last so it wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) desc_q[i] <= '0;
      start_q <= '0;
      done_q  <= '0;
    end else begin
      if (ev_accept) begin
        desc_q[ml_ch]  <= step_d;
        start_q[ml_ch] <= 1'b0;
        if (step_last) done_q[ml_ch] <= 1'b1;
      end
      if (link_fire) start_q[link_idx] <= 1'b1;
      if (reg_we && acc_hit) begin
        case (acc_word)
          W_DADDR: desc_q[acc_ch].daddr <= reg_wdata;
          W_ITER: begin
            desc_q[acc_ch].citer <= reg_wdata[31:16];
            desc_q[acc_ch].doff  <= reg_wdata[15:0];
          end
          W_FLAGS: begin
            start_q[acc_ch] <= reg_wdata[0];
            done_q[acc_ch]  <= reg_wdata[1];
          end
          W_RELD: begin
            desc_q[acc_ch].biter <= reg_wdata[31:16];
            desc_q[acc_ch].mlen  <= reg_wdata[7];
            desc_q[acc_ch].mlch  <= reg_wdata[5:0];
          end
          default: ;
        endcase
      end
    end
  end

  // read view
  always_comb begin
    reg_rdata = '0;
    if (acc_hit) begin
      case (acc_word)
        W_DADDR: reg_rdata = desc_q[acc_ch].daddr;
        W_ITER:  reg_rdata = {desc_q[acc_ch].citer, desc_q[acc_ch].doff};
        W_FLAGS: reg_rdata = {30'd0, done_q[acc_ch], start_q[acc_ch]};
        W_RELD:  reg_rdata = {desc_q[acc_ch].biter, 8'd0, desc_q[acc_ch].mlen,
                              1'b0, desc_q[acc_ch].mlch};
        default: reg_rdata = '0;
      endcase
    end
  end

  assign start_o = start_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dma_iter_link_chk.sv
module dma_iter_link_chk #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              ml_done,
  input logic [CH_W-1:0]   ml_ch,
  input logic [NUM_CH-1:0] start_o,
  input logic [NUM_CH-1:0] done_o,
  input logic [NUM_CH-1:0] cfg_err_o,
  input logic              link_fire,
  input logic [5:0]        link_tgt,
  input logic              major_fire,
  input logic              minor_link,
  input logic              major_link
);
  logic [CH_W-1:0] tgt_q, ch_q;
  logic            ml_valid;

  assign ml_valid = {{(32-CH_W){1'b0}}, ml_ch} < 32'(NUM_CH);

  always_ff @(posedge clk) begin
    tgt_q <= link_tgt[CH_W-1:0];
    ch_q  <= ml_ch;
  end

  a_r6_no_minor_link_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    major_fire |-> !minor_link);

  a_r9_error_blocks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ml_done && ml_valid && cfg_err_o[ml_ch]) |-> (!link_fire && !major_fire));

  a_r5_link_arms_target: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fire && !reg_we) |=> start_o[tgt_q]);

  a_r6_done_after_major: assert property (@(posedge clk) disable iff (!rst_n)
    (major_fire && !reg_we) |=> done_o[ch_q]);

  a_r7_target_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    link_fire |-> ({26'd0, link_tgt} < 32'(NUM_CH)));

  a_r7_major_link_needs_major: assert property (@(posedge clk) disable iff (!rst_n)
    major_link |-> major_fire);
endmodule

bind dma_iter_link dma_iter_link_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_dma_iter_link.sv
module test_dma_iter_link;
  localparam int NCH = 8;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ml_done = 1'b0;
  logic [2:0] ml_ch = '0;
  logic [NCH-1:0] start_o, done_o, cfg_err_o;
  logic link_fire, major_fire;
  logic [5:0] link_tgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_iter_link #(.NUM_CH(NCH)) i_dma_iter_link (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [31:0] m_daddr [NCH];
  logic [15:0] m_citer [NCH], m_doff [NCH], m_biter [NCH];
  logic        m_mlen [NCH];
  logic [5:0]  m_mlch [NCH];
  logic [NCH-1:0] m_start = '0, m_done = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_err(input int c);
    bit e = 0;
    if (m_citer[c][15] != m_biter[c][15]) e = 1;
    if (m_citer[c][15] && int'(m_citer[c][14:9]) >= NCH) e = 1;
    if (m_mlen[c] && int'(m_mlch[c]) >= NCH) e = 1;
    return e;
  endfunction

  function automatic int m_count(input int c);
    if (m_citer[c][15]) return int'(m_citer[c] & 16'h01FF);
    return int'(m_citer[c] & 16'h7FFF);
  endfunction

  function automatic logic [31:0] m_word(input int c, input int w);
    case (w)
      4: return m_daddr[c];
      5: return {m_citer[c], m_doff[c]};
      6: return {30'd0, m_done[c], m_start[c]};
      7: return {m_biter[c], 8'd0, m_mlen[c], 1'b0, m_mlch[c]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_write(input int addr, input logic [31:0] d);
    int c = addr / 32;
    int w = (addr / 4) % 8;
    if (c >= NCH) return;
    case (w)
      4: m_daddr[c] = d;
      5: begin m_citer[c] = d[31:16]; m_doff[c] = d[15:0]; end
      6: begin m_start[c] = d[0]; m_done[c] = d[1]; end
      7: begin m_biter[c] = d[31:16]; m_mlen[c] = d[7]; m_mlch[c] = d[5:0]; end
      default: ;
    endcase
  endtask

  // one clock: drive at negedge, check events, clock, update model, check flags
  task automatic cycle(input bit do_ml, input int ch, input bit do_wr,
                       input int waddr, input logic [31:0] wd);
    bit acc, last, lnk;
    int tgt;
    ml_done = do_ml; ml_ch = 3'(ch);
    reg_we = do_wr; reg_addr = AW'(waddr); reg_wdata = wd;
    #1;
    acc  = do_ml && !m_err(ch);
    last = m_count(ch) <= 1;
    lnk  = acc && (last ? m_mlen[ch] : m_citer[ch][15]);
    tgt  = last ? int'(m_mlch[ch]) : int'(m_citer[ch][14:9]);
    chk("R6 major_fire", 64'(major_fire), 64'(acc && last));
    if (last) chk("R7 link_fire", 64'(link_fire), 64'(lnk));
    else      chk("R5 link_fire", 64'(link_fire), 64'(lnk));
    if (lnk) chk("R5 link_tgt", 64'(link_tgt), 64'(tgt));
    @(posedge clk);
    if (acc) begin
      m_daddr[ch] = m_daddr[ch] + 32'($signed(m_doff[ch]));
      m_start[ch] = 1'b0;
      if (last) begin m_citer[ch] = m_biter[ch]; m_done[ch] = 1'b1; end
      else m_citer[ch] = m_citer[ch] - 16'd1;
      if (lnk) m_start[tgt] = 1'b1;
    end
    if (do_wr) m_write(waddr, wd);
    @(negedge clk);
    ml_done = 0; reg_we = 0;
    #1;
    chk("R8 start_o", 64'(start_o), 64'(m_start));
    chk("R6 done_o", 64'(done_o), 64'(m_done));
    for (int c = 0; c < NCH; c++) chk("R9 cfg_err_o", 64'(cfg_err_o[c]), 64'(m_err(c)));
  endtask

  task automatic rd_chk(input int c);
    for (int w = 0; w < 8; w++) begin
      reg_addr = AW'(c*32 + w*4);
      #1;
      if (w == 4)      chk("R3 daddr read", 64'(reg_rdata), 64'(m_word(c, w)));
      else if (w == 5) chk("R4 iter word read", 64'(reg_rdata), 64'(m_word(c, w)));
      else             chk("R2 word read", 64'(reg_rdata), 64'(m_word(c, w)));
    end
  endtask

  task automatic wr(input int c, input int w, input logic [31:0] d);
    cycle(0, 0, 1, c*32 + w*4, d);
  endtask

  function automatic logic [31:0] rand_iter(input int c);
    logic [15:0] it;
    bit el = ($urandom % 6 == 0) ? !m_biter[c][15] : m_biter[c][15];
    if (el) it = {1'b1, 6'($urandom % 10), 9'(1 + $urandom % 4)};
    else    it = {1'b0, 15'(1 + $urandom % 4)};
    return {it, 16'($urandom)};
  endfunction

  function automatic logic [31:0] rand_reload();
    logic [15:0] it;
    if ($urandom % 2 == 1) it = {1'b1, 6'($urandom % NCH), 9'(1 + $urandom % 5)};
    else                   it = {1'b0, 15'(1 + $urandom % 5)};
    return {it, 8'd0, 1'($urandom % 2), 1'b0, 6'($urandom % 10)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < NCH; c++) begin
      m_daddr[c] = 0; m_citer[c] = 0; m_doff[c] = 0; m_biter[c] = 0;
      m_mlen[c] = 0; m_mlch[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 start_o reset", 64'(start_o), 64'd0);
    chk("R1 done_o reset", 64'(done_o), 64'd0);
    chk("R1 cfg_err_o reset", 64'(cfg_err_o), 64'd0);
    rd_chk(0);
    rd_chk(NCH-1);

    // R2 unmapped words ignore writes
    wr(1, 0, 32'hDEAD_BEEF);
    wr(1, 3, 32'h1234_5678);
    reg_addr = AW'(1*32 + 0); #1;
    chk("R2 unmapped word", 64'(reg_rdata), 64'd0);
    rd_chk(1);

    // directed: self-link, negative step wrap, final suppression, completion link
    wr(2, 7, {1'b1, 6'd2, 9'd3, 8'd0, 1'b1, 1'b0, 6'd5});
    wr(2, 5, {1'b1, 6'd2, 9'd3, 16'hFFFC});
    wr(2, 4, 32'h0000_0002);
    wr(2, 6, 32'h1);
    cycle(1, 2, 0, 0, 0);
    chk("R8 self-link keeps start", 64'(start_o[2]), 64'd1);
    reg_addr = AW'(2*32 + 16); #1;
    chk("R3 negative step wraps", 64'(reg_rdata), 64'hFFFF_FFFE);
    reg_addr = AW'(2*32 + 20); #1;
    chk("R4 only count decrements", 64'(reg_rdata[31:16]), 64'({1'b1, 6'd2, 9'd2}));
    cycle(1, 2, 0, 0, 0);
    ml_done = 1; ml_ch = 3'd2; #1;
    chk("R6 final has major_fire", 64'(major_fire), 64'd1);
    chk("R7 completion target", 64'(link_tgt), 64'd5);
    ml_done = 0;
    cycle(1, 2, 0, 0, 0);
    chk("R7 completion start set", 64'(start_o[5]), 64'd1);
    chk("R8 serviced start cleared", 64'(start_o[2]), 64'd0);
    chk("R6 done set", 64'(done_o[2]), 64'd1);
    reg_addr = AW'(2*32 + 20); #1;
    chk("R6 reload from biter", 64'(reg_rdata[31:16]), 64'({1'b1, 6'd2, 9'd3}));

    // directed: configuration errors
    wr(3, 5, {1'b1, 6'd1, 9'd4, 16'h0010});
    wr(3, 4, 32'h0000_1000);
    chk("R9 flag mismatch", 64'(cfg_err_o[3]), 64'd1);
    cycle(1, 3, 0, 0, 0);
    reg_addr = AW'(3*32 + 16); #1;
    chk("R9 errored channel unchanged", 64'(reg_rdata), 64'h0000_1000);
    wr(4, 7, {1'b1, 6'd0, 9'd2, 8'd0, 8'd0});
    wr(4, 5, {1'b1, 6'd9, 9'd2, 16'h0001});
    chk("R9 link channel out of range", 64'(cfg_err_o[4]), 64'd1);

    // directed: write racing an update
    wr(6, 7, {16'h0003, 16'd0});
    wr(6, 5, {16'h0003, 16'h0004});
    cycle(1, 6, 1, 6*32 + 20, {16'h0009, 16'h0008});
    reg_addr = AW'(6*32 + 20); #1;
    chk("R10 write wins", 64'(reg_rdata), 64'h0009_0008);
    reg_addr = AW'(6*32 + 16); #1;
    chk("R10 other word updated", 64'(reg_rdata), 64'h0000_0004);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 10;
      int c = $urandom % NCH;
      if (r < 4) cycle(1, c, 0, 0, 0);
      else if (r < 8) begin
        int w = 3 + $urandom % 5;
        logic [31:0] d;
        case (w)
          5: d = rand_iter(c);
          6: d = 32'($urandom % 4);
          7: d = rand_reload();
          default: d = $urandom;
        endcase
        wr(c, w, d);
      end else rd_chk(c);
    end
    for (int c = 0; c < NCH; c++) rd_chk(c);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule